// File: doc/BRIEF.md
# Set/Clear-Enable Interrupt Controller

This block gathers level-sensitive interrupt requests from up to `NUM_SRC` peripheral sources and presents them to a processor on a single active-low request line. It samples every request line each clock into a raw status word. Nothing is held sticky inside the controller: a source clears its bit by dropping its request. An enable mask gates the raw word into a masked status word. The processor line `irq_n` goes low whenever any masked bit is set.

Software never writes the mask directly. One register turns enable bits on for each 1 written. A second register turns enable bits off for each 1 written. Zeros written to either register leave the mask alone, so no read-modify-write sequence is ever needed. Request lines 0 and 1 are reserved for the end-of-count requests of the first and second system timers. The remaining lines are free for other peripherals.

The register port is a synchronous word-wide bus. `bus_addr` is a word index. A read issued with `bus_rd` shows up on `bus_rdata` one clock later and stays there until the next read.

Top module: `irqc_setclr`

## Requirements
- R1: Writing word index 2 (enable-set) sets every enable bit whose data bit is 1.
- R2: Writing word index 3 (enable-clear) clears every enable bit whose data bit is 1.
- R3: Data bits written as 0 to the enable-set or enable-clear register leave the corresponding enable bits unchanged.
- R4: Reading word index 2 returns the current enable mask in bits `NUM_SRC-1:0`.
- R5: Reading word index 3 always returns zero.
- R6: Word index 1 (raw status) returns the request levels sampled at the previous clock edge. The word is not sticky: a bit falls as soon as its request falls.
- R7: Word index 0 (masked status) returns the raw status ANDed bit by bit with the enable mask.
- R8: `irq_n` is 0 exactly when at least one masked status bit is 1, and is 1 otherwise.
- R9: While `rst_n` is low at a clock edge, the enable mask, the raw status and `bus_rdata` become zero, so `irq_n` is 1 after reset.
- R10: Reads from word indices 4 and above return zero. Writes to indices 0, 1 and 4 and above do not change the enable mask.
- R11: Read data bits at `NUM_SRC` and above are always zero. Written data bits at those positions are ignored.
- R12: Request line 0 (timer 1 end-of-count) drives raw status bit 0. Request line 1 (timer 2 end-of-count) drives raw status bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Level interrupt requests; bit 0 is timer 1, bit 1 is timer 2 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
Some properties are checked on every clock by assertions:
- a set write adds bits to the mask;
- a clear write removes its bits;
- with no write, the mask holds;
- the raw word tracks the previous request levels;
- `irq_n` agrees with the masked word;
- a read of the clear register gives zero.

Other behaviour only the directed scenarios can show. These are the address map and the placement of bit fields on the read port, and the ignored upper data bits. Also scenario-only are the writes to read-only or unmapped indices that leave the mask untouched, and the end-to-end path from a timer request through the mask to the processor line.

// File: rtl/irqc_pkg.sv
// Package: shared register map and read-select type for the set/clear-enable
// interrupt controller. Assumes word-indexed addressing on the register bus.
package irqc_pkg;

    // Word indices of the registers
    localparam int unsigned IDX_MASKED = 0;
    localparam int unsigned IDX_RAW    = 1;
    localparam int unsigned IDX_ENSET  = 2;
    localparam int unsigned IDX_ENCLR  = 3;

    // Which value the read port returns
    typedef enum logic [2:0] {
        RSEL_ZERO   = 3'd0,
        RSEL_MASKED = 3'd1,
        RSEL_RAW    = 3'd2,
        RSEL_ENABLE = 3'd3
    } rsel_t;

endpackage

// File: rtl/irqc_decode.sv
// Module: irqc_decode
// Decodes one bus access into enable-set / enable-clear strobes and a read
// selector. Assumes at most one register is addressed per cycle; unmapped
// indices and the clear register read as zero.
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              set_stb,
    output logic              clr_stb,
    output logic              rd_stb,
    output rsel_t             rd_sel
);

    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(IDX_MASKED);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(IDX_RAW);
    localparam logic [ADDR_W-1:0] A_ENSET  = ADDR_W'(IDX_ENSET);
    localparam logic [ADDR_W-1:0] A_ENCLR  = ADDR_W'(IDX_ENCLR);

    // Write strobes: only the two mask-update registers accept writes
    always_comb begin
        set_stb = bus_wr && (bus_addr == A_ENSET);
        clr_stb = bus_wr && (bus_addr == A_ENCLR);
    end

    // Read selection: the clear register and unmapped indices give zero
    always_comb begin
        rd_stb = bus_rd;
        unique case (bus_addr)
            A_MASKED: rd_sel = RSEL_MASKED;
            A_RAW:    rd_sel = RSEL_RAW;
            A_ENSET:  rd_sel = RSEL_ENABLE;
            default:  rd_sel = RSEL_ZERO;
        endcase
    end

endmodule

// File: rtl/irqc_enable.sv
// Module: irqc_enable
// Holds the enable mask, one flop per source, updated only by write-one-to-set
// and write-one-to-clear strobes. A clear beats a set on the same bit.
// Assumes synchronous active-low reset to an all-disabled mask.
module irqc_enable #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] en_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic do_set;
        logic do_clr;

        // Per-bit update requests
        always_comb begin
            do_set = set_stb && wbits[i];
            do_clr = clr_stb && wbits[i];
        end

        // Per-bit enable flop, clear has priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[i] <= 1'b0;
            else if (do_clr)
                en_q[i] <= 1'b0;
            else if (do_set)
                en_q[i] <= 1'b1;
        end
    end

    assert_set_adds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((en_q & $past(wbits)) == $past(wbits)));

    assert_clear_removes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((en_q & $past(wbits)) == '0));

    assert_zero_bits_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(en_q));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0));

endmodule

// File: rtl/irqc_status.sv
// Module: irqc_status
// Samples the source request levels into a raw status word every cycle,
// masks it with the enable word and drives the active-low processor line.
// Assumes sources are already synchronous to clk; no bit is held sticky.
module irqc_status #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] raw_q,
    output logic [NUM_SRC-1:0] masked,
    output logic               irq_n
);

    // Raw status register: tracks request levels one clock late
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= src_req;
    end

    // Masked status and processor line
    always_comb begin
        masked = raw_q & en;
        irq_n  = ~(|masked);
    end

    assert_raw_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (raw_q == $past(src_req)));

    assert_timer_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (raw_q[1:0] == $past(src_req[1:0])));

endmodule

// File: rtl/irqc_setclr.sv
// Module: irqc_setclr (top)
// Set/clear-enable interrupt controller: bus decode, enable mask, status and
// a registered read port. Assumes NUM_SRC <= DATA_W and NUM_SRC >= 2
// (bits 0 and 1 are the two timer end-of-count requests).
module irqc_setclr
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);

    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(IDX_ENCLR);

    logic               set_stb;
    logic               clr_stb;
    logic               rd_stb;
    rsel_t              rd_sel;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] raw_w;
    logic [NUM_SRC-1:0] masked_w;
    logic [NUM_SRC-1:0] rd_val;

    // Upper write-data bits carry no function
    if (DATA_W > NUM_SRC) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
    end

    assign wbits = bus_wdata[NUM_SRC-1:0];

    irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .rd_stb  (rd_stb),
        .rd_sel  (rd_sel)
    );

    irqc_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_stb(set_stb),
        .clr_stb(clr_stb),
        .wbits  (wbits),
        .en_q   (en_w)
    );

    irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_req(src_req),
        .en     (en_w),
        .raw_q  (raw_w),
        .masked (masked_w),
        .irq_n  (irq_n)
    );

    // Read multiplexer
    always_comb begin
        unique case (rd_sel)
            RSEL_MASKED: rd_val = masked_w;
            RSEL_RAW:    rd_val = raw_w;
            RSEL_ENABLE: rd_val = en_w;
            default:     rd_val = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_stb)
            bus_rdata <= DATA_W'(rd_val);
    end

    assert_clear_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ENCLR) |=> (bus_rdata == '0));

    assert_irq_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|(raw_w & en_w)));

    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_rdata >> NUM_SRC) == '0));

endmodule

// File: tb/irqc_setclr_test.sv
// Directed bench for irqc_setclr: one task per scenario, each checking itself.
module irqc_setclr_test;

    localparam int unsigned NS = 8;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_n;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    irqc_setclr #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        rst_n = 1'b0;
        src_req = 8'hFF;
        repeat (3) @(negedge clk);
        check("R9 rdata in reset", bus_rdata, '0);
        check("R9 irq_n in reset", DW'(irq_n), 1);
        rst_n = 1'b1;
        bus_read(2, d);
        check("R9 mask after reset", d, '0);
        check("R9 irq_n after reset", DW'(irq_n), 1);
        src_req = '0;
    endtask

    task automatic t_set();
        logic [DW-1:0] d;
        bus_write(2, 32'h0000_0005);
        bus_read(2, d);
        check("R1 set 0x05", d, 32'h05);
        bus_write(2, 32'h0000_0030);
        bus_read(2, d);
        check("R4 R3 set 0x30 keeps 0x05", d, 32'h35);
    endtask

    task automatic t_clear();
        logic [DW-1:0] d;
        bus_write(3, 32'h0000_0011);
        bus_read(2, d);
        check("R2 clear 0x11", d, 32'h24);
        bus_write(3, 32'h0);
        bus_write(2, 32'h0);
        bus_read(2, d);
        check("R3 zero writes keep mask", d, 32'h24);
        bus_read(3, d);
        check("R5 clear register reads zero", d, '0);
    endtask

    task automatic t_raw();
        logic [DW-1:0] d;
        @(negedge clk);
        src_req = 8'hA3;
        @(negedge clk);
        bus_read(1, d);
        check("R6 raw follows requests", d, 32'hA3);
        src_req = 8'h00;
        @(negedge clk);
        bus_read(1, d);
        check("R6 raw not sticky", d, 32'h00);
    endtask

    task automatic t_masked_irq();
        logic [DW-1:0] d;
        // mask is 0x24 here
        @(negedge clk);
        src_req = 8'h1B;
        @(negedge clk);
        check("R8 irq_n high, no overlap", DW'(irq_n), 1);
        bus_read(0, d);
        check("R7 masked no overlap", d, 32'h00);
        src_req = 8'h3C;
        @(negedge clk);
        check("R8 irq_n low with overlap", DW'(irq_n), 0);
        bus_read(0, d);
        check("R7 masked overlap", d, 32'h24);
        bus_write(3, 32'h24);
        check("R8 irq_n high after clear", DW'(irq_n), 1);
        src_req = '0;
    endtask

    task automatic t_timers();
        logic [DW-1:0] d;
        bus_write(2, 32'h3);
        @(negedge clk);
        src_req = 8'h01;
        @(negedge clk);
        check("R12 timer1 drives irq", DW'(irq_n), 0);
        bus_read(0, d);
        check("R12 timer1 bit0", d, 32'h01);
        src_req = 8'h02;
        @(negedge clk);
        bus_read(1, d);
        check("R12 timer2 bit1", d, 32'h02);
        src_req = '0;
        @(negedge clk);
        check("R12 idle timers irq_n high", DW'(irq_n), 1);
        bus_write(3, 32'h3);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] d;
        bus_write(2, 32'h40);
        bus_write(0, 32'hFF);
        bus_write(1, 32'hFF);
        bus_write(4, 32'hFF);
        bus_write(15, 32'hFF);
        bus_read(2, d);
        check("R10 writes to other indices ignored", d, 32'h40);
        @(negedge clk);
        src_req = 8'hFF;
        @(negedge clk);
        bus_read(7, d);
        check("R10 unmapped read zero", d, '0);
        src_req = '0;
    endtask

    task automatic t_upper();
        logic [DW-1:0] d;
        bus_write(2, 32'hFFFF_FF00);
        bus_read(2, d);
        check("R11 upper set bits ignored", d, 32'h40);
        bus_write(3, 32'hFFFF_FF00);
        bus_read(2, d);
        check("R11 upper clear bits ignored", d, 32'h40);
    endtask

    initial begin
        t_reset();
        t_set();
        t_clear();
        t_raw();
        t_masked_irq();
        t_timers();
        t_unmapped();
        t_upper();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule